// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End for a Display Controller

This block is the host-facing bus port of a display controller that owns a display RAM. Toward the host it has a byte-wide data bus, split into input, output and output-enable so that the pad ring can build the bidirectional pin. It also has an active-low chip select, a register/data select line and two strobe lines. The meaning of the two strobes is fixed at reset. One style uses an enable strobe plus a read/write direction line. The other uses separate active-low read and write strobes. Each completed access is sorted into one of four operations: status read, command write, display data read or display data write.

Toward the core, the block issues single-cycle pulses to the display RAM: read, write and address increment. It also issues a command byte with a valid strobe, and it takes a status byte for direct readback. Host write data is held in an input latch and forwarded as soon as the write strobe ends. Display reads go through an output latch. A read returns what the latch already holds and then refills the latch from RAM, so every burst of display reads starts with one dummy read.

All host inputs pass through a `SYNC_STAGES` register chain before decoding. Every response timing below is counted from the synchronized copy.

Top module: `dual_mode_host_port`

## Requirements
- R1: The level of `mode_pin` in the last clock of reset selects the bus style: 1 gives the separate-strobe style, 0 gives the enable-plus-direction style. The choice holds until the next reset, whatever `mode_pin` does afterwards.
- R2: In enable style, `host_stb_a` is the enable (active high) and `host_stb_b` is the direction (1 = read, 0 = write). With `host_a0`=1 the access targets display data; with `host_a0`=0 it is a status read or a command write. No access happens while the enable is low.
- R3: In separate-strobe style, `host_stb_a` is the read strobe and `host_stb_b` is the write strobe, both active low. `host_a0` selects display data (1) or status/command (0). When both strobes are low together, no access takes place.
- R4: During a status read, `host_d_out` equals `status_in` directly, and no RAM pulse is issued.
- R5: During a display read, `host_d_out` shows the output latch. When the read strobe ends, `ram_rd_en` and `ram_addr_inc` pulse together for one cycle, and the latch takes `ram_rdata` at the end of that cycle. The latch holds 0x00 after reset, so the first display read after reset returns 0x00.
- R6: A display read that starts in the cycle the output latch is being refilled returns the word being loaded, not the old latch content.
- R7: Write data is captured while the write strobe is active. When a display write ends, `ram_wr_en` and `ram_addr_inc` pulse for one cycle, with `ram_wdata` equal to the last captured byte. No dummy access is needed.
- R8: When a command write ends, `cmd_valid` pulses for one cycle, with `cmd_data` equal to the last captured byte. No RAM pulse is issued.
- R9: While `host_cs_n` is high, the bus is not driven and no access takes effect. Raising `host_cs_n` before the strobe ends cancels the access: no pulse is issued and the output latch keeps its value.
- R10: `host_d_oe` is high only while a read is active with chip select low. It falls no more than `SYNC_STAGES` clock edges after the strobe or chip select goes inactive.
- R11: The synchronous active-low `rst_n` clears the latches, the pulses and the bus drive regardless of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin | input | 1 | Bus style level, sampled while in reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_a0 | input | 1 | 1 = display data, 0 = status/command |
| host_stb_a | input | 1 | Enable (enable style) or read strobe, active low (separate-strobe style) |
| host_stb_b | input | 1 | Direction (enable style) or write strobe, active low (separate-strobe style) |
| host_d_in | input | DW | Data from the host bus pins |
| host_d_out | output | DW | Data to the host bus pins |
| host_d_oe | output | 1 | Drive enable for the host bus pins |
| status_in | input | DW | Status byte from the core |
| ram_rdata | input | DW | Word at the current RAM address |
| ram_rd_en | output | 1 | One-cycle RAM read pulse |
| ram_wr_en | output | 1 | One-cycle RAM write pulse |
| ram_addr_inc | output | 1 | One-cycle RAM address increment pulse |
| ram_wdata | output | DW | Data for a RAM write |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_data | output | DW | Command byte |

## Verification
Two events can fall in the same cycle: the output latch refilling after one display read, and the first driven cycle of the next display read. The bench provokes this in separate-strobe style by raising the read strobe and dropping it again one clock later. After synchronization, the new read then starts exactly in the refill cycle. The bench samples `host_d_out` in the first cycle that `host_d_oe` is high. It judges that sample against the RAM word its own RAM model held at the pre-refill address, not against the older latch content.

// File: rtl/hbi_pkg.sv
// Shared types for the dual-mode host bus front end.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hbi_pkg;

    // Control lines of the host bus after synchronization.
    typedef struct packed {
        logic cs_n;
        logic a0;
        logic stb_a;
        logic stb_b;
    } host_ctl_t;

    localparam int CTL_W = $bits(host_ctl_t);

    // Deselected, strobes low: no access decodes from this in either style.
    localparam host_ctl_t CTL_IDLE = '{cs_n: 1'b1, a0: 1'b0, stb_a: 1'b0, stb_b: 1'b0};

    // The four operations a completed access can perform.
    typedef enum logic [1:0] {
        OP_STAT_RD = 2'd0,
        OP_CMD_WR  = 2'd1,
        OP_DISP_RD = 2'd2,
        OP_DISP_WR = 2'd3
    } host_op_e;

    // Sorts an access by its data/register select and its direction.
    function automatic host_op_e classify_op(input logic a0, input logic is_read);
        if (a0) return is_read ? OP_DISP_RD : OP_DISP_WR;
        return is_read ? OP_STAT_RD : OP_CMD_WR;
    endfunction

endpackage

// File: rtl/hbi_sync.sv
// Register chain for host-side inputs of width W.
// STAGES = 0 gives a plain wire; otherwise the output lags by STAGES clocks.
// Assumes: the caller resets the chain to a value that decodes as no access.
module hbi_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stage_q [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                if (i == 0) begin : g_first
                    // First stage takes the raw input.
                    always_ff @(posedge clk) begin
                        if (!rst_n) stage_q[i] <= RST_VAL;
                        else        stage_q[i] <= d;
                    end
                end else begin : g_next
                    // Later stages shift the previous stage along.
                    always_ff @(posedge clk) begin
                        if (!rst_n) stage_q[i] <= RST_VAL;
                        else        stage_q[i] <= stage_q[i-1];
                    end
                end
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hbi_mode_decode.sv
// Holds the bus style chosen at reset and turns the two strobe lines into
// style-independent read and write strobes.
// Assumes: ctl is already synchronized; mode_pin is steady during reset.
module hbi_mode_decode
    import hbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_pin,
    input  host_ctl_t ctl,
    output logic      mode_sep,
    output logic      sel,
    output logic      rd_strobe,
    output logic      wr_strobe
);

    // Capture the style level every reset cycle; hold it once out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_sep <= mode_pin;
    end

    // Map the strobe pair onto read/write intent for the held style.
    always_comb begin
        sel = !ctl.cs_n;
        if (mode_sep) begin
            rd_strobe = !ctl.stb_a && ctl.stb_b;
            wr_strobe = !ctl.stb_b && ctl.stb_a;
        end else begin
            rd_strobe = ctl.stb_a && ctl.stb_b;
            wr_strobe = ctl.stb_a && !ctl.stb_b;
        end
    end

    assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_sep))
        else $error("bus style changed outside reset");

    assert_both_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sep && !ctl.stb_a && !ctl.stb_b) |-> (!rd_strobe && !wr_strobe))
        else $error("both strobes low produced an access");

    assert_enable_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sep && !ctl.stb_a) |-> (!rd_strobe && !wr_strobe))
        else $error("access without enable");

endmodule

// File: rtl/hbi_access_ctl.sv
// Tracks access phases and issues one-cycle pulses when an access ends.
// An access completes when its strobe drops while chip select is still low;
// dropping chip select first cancels it.
// Assumes: inputs come from hbi_mode_decode on synchronized lines.
module hbi_access_ctl
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd_strobe,
    input  logic wr_strobe,
    input  logic a0,
    output logic rd_act,
    output logic wr_act,
    output logic disp_rd_p,
    output logic disp_wr_p,
    output logic cmd_p
);

    logic     rd_act_q;
    logic     wr_act_q;
    logic     a0_hold;
    logic     rd_done;
    logic     wr_done;
    host_op_e done_op;

    // Live access phases, gated by chip select.
    always_comb begin
        rd_act  = sel && rd_strobe;
        wr_act  = sel && wr_strobe;
        rd_done = rd_act_q && !rd_strobe && sel;
        wr_done = wr_act_q && !wr_strobe && sel;
        done_op = classify_op(a0_hold, rd_done);
    end

    // Remember last cycle's phases and the select line seen during the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
            a0_hold  <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
            if (rd_act || wr_act) a0_hold <= a0;
        end
    end

    // Issue the completion pulse for the operation that just ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_rd_p <= 1'b0;
            disp_wr_p <= 1'b0;
            cmd_p     <= 1'b0;
        end else begin
            disp_rd_p <= rd_done && (done_op == OP_DISP_RD);
            disp_wr_p <= wr_done && (done_op == OP_DISP_WR);
            cmd_p     <= wr_done && (done_op == OP_CMD_WR);
        end
    end

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_rd_p, disp_wr_p, cmd_p}))
        else $error("more than one completion pulse");

    assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !(disp_rd_p || disp_wr_p || cmd_p))
        else $error("pulse after deselected cycle");

    assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_rd_p |=> !disp_rd_p)
        else $error("read pulse longer than one cycle");

endmodule

// File: rtl/hbi_data_path.sv
// Input and output latches plus the host read mux and drive enable.
// The output latch refills from RAM during the read pulse; a read that is
// live in that same cycle is fed the incoming word directly.
// Assumes: ram_rdata holds the word at the current address in the pulse cycle.
module hbi_data_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          wr_act,
    input  logic          a0,
    input  logic          load,
    input  logic [DW-1:0] d_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] in_latch,
    output logic [DW-1:0] d_out,
    output logic          d_oe
);

    logic [DW-1:0] out_latch;
    logic [DW-1:0] read_word;

    // Input latch follows the bus while a write is active, then holds.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_latch <= '0;
        else if (wr_act) in_latch <= d_in;
    end

    // Output latch takes the RAM word during the read pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_latch <= '0;
        else if (load) out_latch <= ram_rdata;
    end

    // Choose the byte for the host: status, or display data with refill bypass.
    always_comb begin
        read_word = load ? ram_rdata : out_latch;
        d_oe      = rd_act;
        if (!rd_act) d_out = '0;
        else if (a0) d_out = read_word;
        else         d_out = status_in;
    end

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(out_latch))
        else $error("output latch changed without a read pulse");

    assert_inlatch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_act |=> $stable(in_latch))
        else $error("input latch changed outside a write");

endmodule

// File: rtl/dual_mode_host_port.sv
// Host bus front end for a display controller. It synchronizes the host
// lines, decodes them in the style chosen at reset, and forwards writes and
// pipelined display reads to the RAM and command sides.
// Assumes: the pad ring builds the bidirectional pins from d_out/d_oe/d_in;
// the RAM address counter outside steps on ram_addr_inc.
module dual_mode_host_port
    import hbi_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_pin,
    input  logic          host_cs_n,
    input  logic          host_a0,
    input  logic          host_stb_a,
    input  logic          host_stb_b,
    input  logic [DW-1:0] host_d_in,
    output logic [DW-1:0] host_d_out,
    output logic          host_d_oe,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_rd_en,
    output logic          ram_wr_en,
    output logic          ram_addr_inc,
    output logic [DW-1:0] ram_wdata,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_data
);

    host_ctl_t     ctl_raw;
    host_ctl_t     ctl_s;
    logic [DW-1:0] d_in_s;
    logic          mode_sep;
    logic          sel;
    logic          rd_strobe;
    logic          wr_strobe;
    logic          rd_act;
    logic          wr_act;
    logic          disp_rd_p;
    logic          disp_wr_p;
    logic          cmd_p;
    logic [DW-1:0] in_latch;

    // Bundle the raw control pins.
    always_comb begin
        ctl_raw.cs_n  = host_cs_n;
        ctl_raw.a0    = host_a0;
        ctl_raw.stb_a = host_stb_a;
        ctl_raw.stb_b = host_stb_b;
    end

    hbi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    hbi_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (host_d_in),
        .q     (d_in_s)
    );

    hbi_mode_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pin  (mode_pin),
        .ctl       (ctl_s),
        .mode_sep  (mode_sep),
        .sel       (sel),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe)
    );

    hbi_access_ctl u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .a0        (ctl_s.a0),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .disp_rd_p (disp_rd_p),
        .disp_wr_p (disp_wr_p),
        .cmd_p     (cmd_p)
    );

    hbi_data_path #(.DW(DW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .a0        (ctl_s.a0),
        .load      (disp_rd_p),
        .d_in      (d_in_s),
        .status_in (status_in),
        .ram_rdata (ram_rdata),
        .in_latch  (in_latch),
        .d_out     (host_d_out),
        .d_oe      (host_d_oe)
    );

    // Route the completion pulses and the captured byte to the core side.
    always_comb begin
        ram_rd_en    = disp_rd_p;
        ram_wr_en    = disp_wr_p;
        ram_addr_inc = disp_rd_p || disp_wr_p;
        ram_wdata    = in_latch;
        cmd_valid    = cmd_p;
        cmd_data     = in_latch;
    end

    assert_no_drive_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_d_oe |-> !ctl_s.cs_n)
        else $error("bus driven while deselected");

    assert_status_no_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_d_oe && !ctl_s.a0) |=> !ram_wr_en)
        else $error("RAM write right after status read cycle");

    assert_quiet_after_reset_R11: assert property (@(posedge clk)
        !rst_n |=> !(ram_rd_en || ram_wr_en || cmd_valid || host_d_oe))
        else $error("activity right after reset cycle");

    assert_mode_style_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sep && ctl_s.stb_a && ctl_s.stb_b) |-> !host_d_oe)
        else $error("drive with both active-low strobes idle");

endmodule

// File: tb/dual_mode_host_port_tb.sv
`timescale 1ns/1ps
module dual_mode_host_port_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_pin = 1'b0;
    logic          host_cs_n = 1'b1;
    logic          host_a0 = 1'b0;
    logic          host_stb_a = 1'b0;
    logic          host_stb_b = 1'b1;
    logic [DW-1:0] host_d_in = '0;
    logic [DW-1:0] host_d_out;
    logic          host_d_oe;
    logic [DW-1:0] status_in = 8'h5A;
    logic [DW-1:0] ram_rdata;
    logic          ram_rd_en, ram_wr_en, ram_addr_inc, cmd_valid;
    logic [DW-1:0] ram_wdata, cmd_data;

    int errors = 0;
    int checks = 0;
    int cnt_rd = 0, cnt_wr = 0, cnt_cmd = 0;
    logic [DW-1:0] last_cmd = '0;
    logic sep_style = 1'b0;
    logic ram_clear = 1'b1;
    logic [DW-1:0] mem [8];
    logic [2:0] raddr;

    always #5 clk = ~clk;

    dual_mode_host_port #(.DW(DW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .host_cs_n(host_cs_n),
        .host_a0(host_a0), .host_stb_a(host_stb_a), .host_stb_b(host_stb_b),
        .host_d_in(host_d_in), .host_d_out(host_d_out), .host_d_oe(host_d_oe),
        .status_in(status_in), .ram_rdata(ram_rdata), .ram_rd_en(ram_rd_en),
        .ram_wr_en(ram_wr_en), .ram_addr_inc(ram_addr_inc), .ram_wdata(ram_wdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data)
    );

    // RAM model with its own address counter.
    assign ram_rdata = mem[raddr];
    always @(posedge clk) begin
        if (ram_clear) begin
            raddr <= '0;
            for (int i = 0; i < 8; i++) mem[i] <= 8'hA0 + 8'(i);
        end else begin
            if (ram_wr_en) mem[raddr] <= ram_wdata;
            if (ram_addr_inc) raddr <= raddr + 3'd1;
        end
    end

    // Pulse counters, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_rd_en) cnt_rd++;
            if (ram_wr_en) cnt_wr++;
            if (cmd_valid) begin cnt_cmd++; last_cmd = cmd_data; end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        if (sep_style) begin host_stb_a = 1'b1; host_stb_b = 1'b1; end
        else begin host_stb_a = 1'b0; host_stb_b = 1'b1; end
    endtask

    task automatic do_reset(input logic sep, input logic cs_during);
        @(negedge clk);
        rst_n = 1'b0; ram_clear = 1'b1; mode_pin = sep; sep_style = sep;
        host_cs_n = cs_during; set_idle();
        repeat (4) @(negedge clk);
        chk("R11 oe in reset", host_d_oe, 1'b0);
        rst_n = 1'b1; ram_clear = 1'b0; host_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        mode_pin = ~sep;
        cnt_rd = 0; cnt_wr = 0; cnt_cmd = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic a0, output logic [DW-1:0] data, output logic oe);
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = a0;
        if (sep_style) host_stb_a = 1'b0;
        else begin host_stb_b = 1'b1; host_stb_a = 1'b1; end
        repeat (4) @(negedge clk);
        data = host_d_out; oe = host_d_oe;
        set_idle();
        repeat (2) @(negedge clk);
        chk("R10 oe released", host_d_oe, 1'b0);
        repeat (3) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_write(input logic a0, input logic [DW-1:0] data);
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = a0; host_d_in = data;
        if (sep_style) host_stb_b = 1'b0;
        else begin host_stb_b = 1'b0; host_stb_a = 1'b1; end
        repeat (4) @(negedge clk);
        chk("R7 no drive in write", host_d_oe, 1'b0);
        set_idle();
        repeat (6) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R11 oe after reset", host_d_oe, 1'b0);
        chk("R11 no pulses", cnt_rd + cnt_wr + cnt_cmd, 0);
    endtask

    task automatic t_status(input logic [DW-1:0] st, input string tag);
        logic [DW-1:0] d; logic oe;
        status_in = st;
        bus_read(1'b0, d, oe);
        chk({tag, " R4 status data"}, d, st);
        chk({tag, " R4 status oe"}, oe, 1'b1);
        chk({tag, " R4 no ram read"}, cnt_rd, 0);
    endtask

    task automatic t_burst68();
        logic [DW-1:0] d; logic oe;
        bus_read(1'b1, d, oe); chk("R5 dummy read", d, 8'h00);
        bus_read(1'b1, d, oe); chk("R5 second read", d, 8'hA0);
        bus_read(1'b1, d, oe); chk("R5 third read", d, 8'hA1);
        chk("R5 read pulses", cnt_rd, 3);
        chk("R5 address stepped", raddr, 3);
    endtask

    task automatic t_cmd(input logic [DW-1:0] c, input string tag);
        int w0 = cnt_wr, c0 = cnt_cmd;
        bus_write(1'b0, c);
        chk({tag, " R8 cmd count"}, cnt_cmd, c0 + 1);
        chk({tag, " R8 cmd data"}, last_cmd, c);
        chk({tag, " R8 no ram write"}, cnt_wr, w0);
    endtask

    task automatic t_dwrite(input logic [DW-1:0] v, input string tag);
        logic [2:0] a = raddr;
        bus_write(1'b1, v);
        chk({tag, " R7 ram word"}, mem[a], v);
        chk({tag, " R7 address step"}, raddr, a + 3'd1);
    endtask

    task automatic t_standby();
        int r0 = cnt_rd, w0 = cnt_wr, c0 = cnt_cmd;
        @(negedge clk);
        host_cs_n = 1'b1; host_a0 = 1'b1; host_stb_b = 1'b1; host_stb_a = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 no drive deselected", host_d_oe, 1'b0);
        host_stb_a = 1'b0; repeat (2) @(negedge clk);
        host_stb_b = 1'b0; host_stb_a = 1'b1; repeat (4) @(negedge clk);
        set_idle(); repeat (5) @(negedge clk);
        chk("R9 no pulses deselected", (cnt_rd - r0) + (cnt_wr - w0) + (cnt_cmd - c0), 0);
    endtask

    task automatic t_cancel(input logic [DW-1:0] latch_exp);
        logic [DW-1:0] d; logic oe;
        int r0 = cnt_rd;
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = 1'b1; host_stb_b = 1'b1; host_stb_a = 1'b1;
        repeat (4) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 drive dropped on deselect", host_d_oe, 1'b0);
        set_idle(); repeat (5) @(negedge clk);
        chk("R9 cancelled read no pulse", cnt_rd, r0);
        bus_read(1'b1, d, oe);
        chk("R9 latch kept", d, latch_exp);
    endtask

    task automatic t_sep_burst();
        logic [DW-1:0] d; logic oe;
        bus_read(1'b1, d, oe); chk("R5 R1 dummy read sep", d, 8'h00);
        chk("R1 style held oe", oe, 1'b1);
        bus_read(1'b1, d, oe); chk("R5 R3 read sep", d, 8'hA1);
    endtask

    task automatic t_both_low();
        int r0 = cnt_rd, w0 = cnt_wr, c0 = cnt_cmd;
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = 1'b1; host_stb_a = 1'b0; host_stb_b = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 both low no drive", host_d_oe, 1'b0);
        set_idle(); repeat (5) @(negedge clk);
        host_cs_n = 1'b1;
        chk("R3 both low no pulse", (cnt_rd - r0) + (cnt_wr - w0) + (cnt_cmd - c0), 0);
    endtask

    task automatic t_bypass_r6();
        logic [DW-1:0] exp_word = mem[raddr];
        logic [DW-1:0] got = '0;
        logic seen = 1'b0;
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = 1'b1; host_stb_a = 1'b0;
        repeat (4) @(negedge clk);
        host_stb_a = 1'b1;
        @(negedge clk);
        host_stb_a = 1'b0;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            if (host_d_oe) begin seen = 1'b1; got = host_d_out; end
        end
        chk("R6 back-to-back read seen", seen, 1'b1);
        chk("R6 refill bypass data", got, exp_word);
        set_idle(); repeat (5) @(negedge clk);
        host_cs_n = 1'b1; repeat (2) @(negedge clk);
    endtask

    initial begin
        do_reset(1'b0, 1'b1);
        t_reset_state();
        t_status(8'h5A, "R2");
        t_burst68();
        t_cmd(8'h3C, "R2");
        t_dwrite(8'h77, "R2");
        t_standby();
        t_cancel(8'hA2);
        do_reset(1'b1, 1'b0);
        t_reset_state();
        t_status(8'hC3, "R3");
        t_dwrite(8'h99, "R3");
        t_cmd(8'h42, "R3");
        t_sep_burst();
        t_both_low();
        t_bypass_r6();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=running exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule